// File: doc/BRIEF.md
# Row/Column Decoded 16x1 Bit Memory

This block is a sixteen-location memory, one bit wide, built as a square array of four rows and four columns of storage cells. The upper half of the address picks a row through a one-hot row decoder. The lower half picks a column through a second one-hot decoder, and chip select enables that decoder. A cell is selected only where an active row line crosses an active column line, so with chip select low no cell is selected at all.

One read/write line chooses the operation. With the line low and chip select high, the data input is stored into the addressed cell on the rising clock edge. With the line high and chip select high, the addressed cell appears on the data output combinationally from the address. In every other case the output is held at 0. The output is never left floating.

The block uses an active-low reset. Reset is asserted asynchronously, and its release is synchronised to the clock through two flops. Reset clears every cell to 0.

Top module: `bitram_2d`

## Requirements
- R1: Location n sits at row n[3:2] and column n[1:0], that is at row r and column c where n = 4*r + c. Each of the 16 locations holds its own bit independently of the others.
- R2: When chip select is 1 and read/write is 0 at a rising clock edge, the addressed cell takes the value of the data input.
- R3: When chip select is 0 at a rising clock edge, no cell changes, whatever the address, data input and read/write values.
- R4: A read access (chip select 1, read/write 1) changes no cell, whatever the data input value.
- R5: When chip select is 1 and read/write is 1, the data output equals the bit stored at the addressed location in the same cycle, with no clock edge between address and data.
- R6: The data output is 0 whenever chip select is 0 or read/write is 0.
- R7: Asserting the active-low reset clears all 16 cells to 0 at once. The release of reset takes effect at the second rising edge after the input rises, so the third edge is the first that can write.
- R8: A write alters only the addressed cell. Every other cell keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes occur on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Location; bits 3:2 select the row, bits 1:0 select the column |
| din | input | 1 | Bit to be stored on a write |
| rw | input | 1 | 1 selects read, 0 selects write |
| cs | input | 1 | Chip select; enables the column decoder |
| dout | output | 1 | Addressed bit during a read, otherwise 0 |

## Verification
The bench fills the array with a non-symmetric pattern and a walking single one. A design that swaps the row and column halves of the address, or that decodes a column or row line wrongly, returns bits from the wrong location or disturbs a neighbour. Writes and reads with chip select low, and reads carrying opposite data on the input, are followed by a full readback. This catches a column decoder that ignores its enable, and a write gated by chip select or by read/write alone. The output is checked on every cycle against the mode the bench drives, so an output that leaks the stored bit during writes or while deselected shows up at once. A reset applied in the middle of the run must clear a populated array.

// File: rtl/bitram_pkg.sv
package bitram_pkg;
  localparam int unsigned ROW_AW_DEF = 2;
  localparam int unsigned COL_AW_DEF = 2;
endpackage

// File: rtl/bitram_dec.sv
module bitram_dec #(
  parameter int unsigned IN_W  = 2,
  parameter int unsigned OUT_N = 1 << IN_W
) (
  input  logic            en,
  input  logic [IN_W-1:0] code,
  output logic [OUT_N-1:0] line
);
  for (genvar g = 0; g < OUT_N; g++) begin : g_line
    assign line[g] = en && (code == IN_W'(g));
  end
endmodule

// File: rtl/bitram_cell.sv
module bitram_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  logic d,
  output logic q
);
  logic q_nxt;

  always_comb begin
    q_nxt = q;
    if (we) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/bitram_2d.sv
module bitram_2d
  import bitram_pkg::*;
#(
  parameter int unsigned ROW_AW = ROW_AW_DEF,
  parameter int unsigned COL_AW = COL_AW_DEF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ROW_AW+COL_AW-1:0] addr,
  input  logic                     din,
  input  logic                     rw,
  input  logic                     cs,
  output logic                     dout
);
  localparam int unsigned ADDR_W = ROW_AW + COL_AW;
  localparam int unsigned ROWS   = 1 << ROW_AW;
  localparam int unsigned COLS   = 1 << COL_AW;
  localparam int unsigned CELLS  = ROWS * COLS;

  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [ROWS-1:0]  row_ln;
  logic [COLS-1:0]  col_ln;
  logic [CELLS-1:0] cell_sel;
  logic [CELLS-1:0] mem_q;
  logic             wr_act;
  logic             rd_act;

  bitram_dec #(.IN_W(ROW_AW)) u_row_dec (
    .en   (1'b1),
    .code (addr[ADDR_W-1:COL_AW]),
    .line (row_ln)
  );

  bitram_dec #(.IN_W(COL_AW)) u_col_dec (
    .en   (cs),
    .code (addr[COL_AW-1:0]),
    .line (col_ln)
  );

  assign wr_act = ~rw;
  assign rd_act = rw;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int unsigned IDX = r * COLS + c;
      assign cell_sel[IDX] = row_ln[r] & col_ln[c];
      bitram_cell u_cell (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .we    (cell_sel[IDX] & wr_act),
        .d     (din),
        .q     (mem_q[IDX])
      );
    end
  end

  assign dout = rd_act & (|(cell_sel & mem_q));

  // R8
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cs |-> ($countones(cell_sel) == 1));

  // R3
  sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cs |-> (cell_sel == '0));

  // R3
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cs |=> $stable(mem_q));

  // R4
  hold_read_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cs && rw) |=> $stable(mem_q));

  // R2
  write_store_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cs && !rw) |=> (mem_q[$past(addr)] == $past(din)));

  // R5
  read_data_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cs && rw) |-> (dout == mem_q[addr]));

  // R6
  quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(cs && rw) |-> !dout);
endmodule

// File: tb/bitram_2d_tb.sv
`timescale 1ns/1ps
module bitram_2d_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] addr;
  logic       din, rw, cs;
  logic       dout;

  int n_vec  = 0;
  int n_fail = 0;
  bit ref_mem [16];
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bitram_2d dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
    .rw(rw), .cs(cs), .dout(dout)
  );

  // one cycle: drive at negedge, compare output, update model at posedge
  task automatic step(input logic [3:0] a, input logic d, input logic r,
                      input logic c, input string tag);
    bit exp;
    @(negedge clk);
    addr = a; din = d; rw = r; cs = c;
    #1;
    exp = (c && r) ? ref_mem[a] : 1'b0;
    n_vec++;
    if (dout !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%0d cs=%0b rw=%0b dout=%0b expected=%0b",
               tag, a, c, r, dout, exp);
    end
    @(posedge clk);
    if (c && !r && rst_n) ref_mem[a] = d;
  endtask

  task automatic read_all(input string tag);
    for (int i = 0; i < 16; i++) step(4'(i), 1'b0, 1'b1, 1'b1, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 16; i++) ref_mem[i] = 1'b0;
    step(4'd5, 1'b1, 1'b1, 1'b1, "R7");
    step(4'd5, 1'b1, 1'b0, 1'b1, "R7");
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step(4'd0, 1'b1, 1'b0, 1'b0, "R7");
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] pat;
    rst_n = 1'b0; addr = '0; din = 1'b0; rw = 1'b1; cs = 1'b0;
    do_reset();
    read_all("R7");

    // R1 R2 R5: non-symmetric pattern over every location
    pat = 16'hA5C3;
    for (int i = 0; i < 16; i++) step(4'(i), pat[i], 1'b0, 1'b1, "R2");
    read_all("R1");
    pat = 16'h3E81;
    for (int i = 15; i >= 0; i--) step(4'(i), pat[i], 1'b0, 1'b1, "R2");
    read_all("R5");

    // R3: deselected writes and reads of inverted data
    for (int i = 0; i < 16; i++) step(4'(i), ~pat[i], 1'b0, 1'b0, "R3");
    for (int i = 0; i < 16; i++) step(4'(i), ~pat[i], 1'b1, 1'b0, "R3");
    read_all("R3");

    // R4: reads with opposite data on the input
    for (int i = 0; i < 16; i++) step(4'(i), ~pat[i], 1'b1, 1'b1, "R4");
    read_all("R4");

    // R6: output quiet while writing
    for (int i = 0; i < 16; i++) step(4'(i), pat[i], 1'b0, 1'b1, "R6");

    // R8: walking one across a cleared array
    for (int i = 0; i < 16; i++) step(4'(i), 1'b0, 1'b0, 1'b1, "R8");
    for (int k = 0; k < 16; k++) begin
      step(4'(k), 1'b1, 1'b0, 1'b1, "R8");
      read_all("R8");
      step(4'(k), 1'b0, 1'b0, 1'b1, "R8");
    end

    // R7: reset applied to a populated array
    for (int i = 0; i < 16; i++) step(4'(i), 1'b1, 1'b0, 1'b1, "R7");
    do_reset();
    read_all("R7");
    step(4'd9, 1'b1, 1'b0, 1'b1, "R7");
    step(4'd9, 1'b0, 1'b1, 1'b1, "R7");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule